// File: doc/BRIEF.md
# Byte-Wide Host Window onto Word Memory

This block lets a host that can only move one byte per access read and write a 32-bit-wide internal memory. The host sees a small register file selected by a 3-bit index: two address registers and four data-lane registers. The address registers hold a word address and an access mode. Data passes through a 32-bit staging word. The block drives a synchronous memory port with per-lane write enables, and the memory returns read data one cycle after the request.

In the word modes, a host read of lane 0 fetches the whole word into the staging register. Lanes 1 to 3 are then read from the staging register with no further memory access. Host writes to lanes 0 to 2 only stage bytes; the write to lane 3 stores the whole word in one memory cycle. In the auto-advancing word mode, the address moves on by one word after the lane-3 access, so the host can stream words without reprogramming the address. In the byte modes, each lane access touches only its own lane in memory.

Top module: `emi_window`

## Requirements
- R1: After reset the word address is 0 and the mode is 00, so both address registers read 0x00.
- R2: Writing index 0 loads word-address bits [5:0] (byte address bits [7:2]) from data bits [7:2] and the mode from bits [1:0]. Reading index 0 returns {address bits [5:0], mode}. Modes: 00 byte, 01 treated as byte, 10 word, 11 word with auto-advance.
- R3: Writing index 1 loads word-address bits [12:6] (byte address bits [14:8]) from data bits [6:0]. Data bit 7 is ignored and reads back as 0.
- R4: In modes 10 and 11, reading index 4 (lane 0) issues one memory read at the current word address and returns bits [7:0]. Reading indices 5, 6 and 7 returns bits [15:8], [23:16] and [31:24] of that staged word with no memory access.
- R5: In modes 10 and 11, writes to indices 4 to 6 only stage their lanes. A write to index 7 issues exactly one memory write with all four enables set and data {lane3, lane2, lane1, lane0}.
- R6: In mode 11 the word address advances by one after a lane-3 read or a lane-3 write, and the address registers show the new value. In mode 10 the address does not change.
- R7: Advancing from word address 0x1FFF wraps to 0.
- R8: In modes 00 and 01, reading lane n fetches the word and returns only bits [8n+7:8n]. Writing lane n issues one memory write with only enable n set, leaving the other lanes unchanged. The address never advances in these modes.
- R9: Writing either address register discards any staged bytes and issues no memory write. A later lane-3 write in a word mode stores zeros in the lanes that were not restaged.
- R10: A read that needs memory holds host_ready low in its first cycle and completes with ready high in the next cycle. Every other access completes with ready high in its first cycle.
- R11: Indices 2 and 3 read as 0x00, and writes to them change neither the address, the mode nor the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 1 | Host access request, held until host_ready |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_idx | input | 3 | Register index: 0/1 address, 4..7 data lanes 0..3 |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, valid while host_ready is high |
| host_ready | output | 1 | Access completes on the clock edge where this is high |
| mem_en | output | 1 | Memory cycle request |
| mem_we | output | 1 | Memory write when high, read when low |
| mem_be | output | 4 | Per-lane write enables |
| mem_addr | output | 13 | Memory word address |
| mem_wdata | output | 32 | Memory write word |
| mem_rdata | input | 32 | Memory read word, one cycle after a read request |

## Verification
The bench streams words in both directions across a word boundary. A design that advanced on the wrong lane, or fetched on every lane, would show a shifted stream or extra memory reads. It programs address 0x1FFF and stores a word, so a carry into a missing bit or a saturating counter shows in the readback. In byte mode it checks that a lane write leaves the neighbouring lanes intact and that the address stays put. Finally, it interrupts a partly staged word with an address write: a design that kept the stale bytes or flushed them early would store the wrong word or write too many times.

// File: rtl/emi_pkg.sv
package emi_pkg;
    localparam int ADDR_W  = 15;
    localparam int WADDR_W = ADDR_W - 2;
    localparam int LO_W    = 6;
    localparam int HI_W    = WADDR_W - LO_W;
    localparam int LANES   = 4;
    localparam int BYTE_W  = 8;
    localparam int WORD_W  = LANES * BYTE_W;
    localparam int LANE_W  = $clog2(LANES);
    localparam int IDX_W   = 3;

    localparam logic [IDX_W-1:0] IDX_ADR_LO = 3'd0;
    localparam logic [IDX_W-1:0] IDX_ADR_HI = 3'd1;

    typedef enum logic [1:0] {
        MODE_B8    = 2'b00,
        MODE_B16   = 2'b01,
        MODE_W32   = 2'b10,
        MODE_W32AI = 2'b11
    } mode_e;

    typedef enum logic {ST_IDLE, ST_FETCH} st_e;

    typedef struct packed {
        logic              ld_lo;
        logic              ld_hi;
        logic              inc;
        logic              clr;
        logic              ld_word;
        logic              ld_lane;
        logic [LANE_W-1:0] lane;
        logic [BYTE_W-1:0] bval;
    } ctl_t;

    function automatic logic word_mode(mode_e m);
        return m[1];
    endfunction

    function automatic logic [LANES-1:0] lane_bit(logic [LANE_W-1:0] l);
        logic [LANES-1:0] r;
        r    = '0;
        r[l] = 1'b1;
        return r;
    endfunction

    function automatic logic [BYTE_W-1:0] pick_lane(logic [WORD_W-1:0] w,
                                                    logic [LANE_W-1:0] l);
        logic [WORD_W-1:0] s;
        s = w >> {l, 3'b000};
        return s[BYTE_W-1:0];
    endfunction
endpackage

// File: rtl/emi_addr_regs.sv
module emi_addr_regs
    import emi_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               ld_lo,
    input  logic               ld_hi,
    input  logic               inc,
    input  logic [BYTE_W-1:0]  lo_val,
    input  logic [HI_W-1:0]    hi_val,
    output logic [WADDR_W-1:0] waddr,
    output mode_e              mode
);
    always_ff @(posedge clk) begin
        if (rst) begin
            waddr <= '0;
            mode  <= MODE_B8;
        end else if (ld_lo) begin
            waddr[LO_W-1:0] <= lo_val[BYTE_W-1:2];
            mode            <= mode_e'(lo_val[1:0]);
        end else if (ld_hi) begin
            waddr[WADDR_W-1:LO_W] <= hi_val;
        end else if (inc) begin
            waddr <= waddr + 1'b1;
        end
    end
endmodule

// File: rtl/emi_hold.sv
module emi_hold
    import emi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              ld_word,
    input  logic [WORD_W-1:0] word_in,
    input  logic              ld_lane,
    input  logic [LANE_W-1:0] lane,
    input  logic [BYTE_W-1:0] bval,
    output logic [WORD_W-1:0] hold
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [BYTE_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst || clr)
                q <= '0;
            else if (ld_word)
                q <= word_in[l*BYTE_W +: BYTE_W];
            else if (ld_lane && lane == LANE_W'(l))
                q <= bval;
        end
        assign hold[l*BYTE_W +: BYTE_W] = q;
    end
endmodule

// File: rtl/emi_ctrl.sv
module emi_ctrl
    import emi_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               host_sel,
    input  logic               host_wr,
    input  logic [IDX_W-1:0]   host_idx,
    input  logic [BYTE_W-1:0]  host_wdata,
    input  mode_e              mode,
    input  logic [WADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0]  hold,
    input  logic [WORD_W-1:0]  mem_rdata,
    output ctl_t               ctl,
    output logic               host_ready,
    output logic [BYTE_W-1:0]  host_rdata,
    output logic               mem_en,
    output logic               mem_we,
    output logic [LANES-1:0]   mem_be,
    output logic [WADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0]  mem_wdata
);
    st_e st, st_n;

    logic [LANE_W-1:0] lane;
    logic              is_lane, wm, ai, last_lane, need_fetch;

    assign lane       = host_idx[LANE_W-1:0];
    assign is_lane    = host_idx[IDX_W-1];
    assign wm         = word_mode(mode);
    assign ai         = (mode == MODE_W32AI);
    assign last_lane  = (lane == LANE_W'(LANES - 1));
    assign need_fetch = host_sel && !host_wr && is_lane && (!wm || lane == '0);

    always_comb begin
        st_n        = st;
        ctl         = '0;
        ctl.lane    = lane;
        ctl.bval    = host_wdata;
        host_ready  = 1'b0;
        host_rdata  = '0;
        mem_en      = 1'b0;
        mem_we      = 1'b0;
        mem_be      = '0;
        mem_addr    = waddr;
        mem_wdata   = {LANES{host_wdata}};
        unique case (st)
            ST_IDLE: begin
                if (need_fetch) begin
                    mem_en = 1'b1;
                    st_n   = ST_FETCH;
                end else if (host_sel) begin
                    host_ready = 1'b1;
                    if (host_wr) begin
                        if (host_idx == IDX_ADR_LO) begin
                            ctl.ld_lo = 1'b1;
                            ctl.clr   = 1'b1;
                        end else if (host_idx == IDX_ADR_HI) begin
                            ctl.ld_hi = 1'b1;
                            ctl.clr   = 1'b1;
                        end else if (is_lane) begin
                            ctl.ld_lane = 1'b1;
                            if (!wm) begin
                                mem_en = 1'b1;
                                mem_we = 1'b1;
                                mem_be = lane_bit(lane);
                            end else if (last_lane) begin
                                mem_en    = 1'b1;
                                mem_we    = 1'b1;
                                mem_be    = '1;
                                mem_wdata = {host_wdata, hold[WORD_W-BYTE_W-1:0]};
                                ctl.inc   = ai;
                            end
                        end
                    end else begin
                        if (host_idx == IDX_ADR_LO)
                            host_rdata = {waddr[LO_W-1:0], mode};
                        else if (host_idx == IDX_ADR_HI)
                            host_rdata = BYTE_W'(waddr[WADDR_W-1:LO_W]);
                        else if (is_lane) begin
                            host_rdata = pick_lane(hold, lane);
                            ctl.inc    = ai && last_lane;
                        end
                    end
                end
            end
            ST_FETCH: begin
                host_ready = 1'b1;
                host_rdata = pick_lane(mem_rdata, lane);
                ctl.bval   = host_rdata;
                ctl.ld_word = wm;
                ctl.ld_lane = !wm;
                st_n       = ST_IDLE;
            end
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= ST_IDLE;
        else     st <= st_n;
    end

    // R10
    fetch_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_en && !mem_we) |-> !host_ready);
    // R10
    fetch_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_en && !mem_we) |=> host_ready);
    // R8
    lane_be_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_en && mem_we && !wm) |-> $countones(mem_be) == 1);
    // R5
    flush_lane_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_en && mem_we && mem_be == '1) |-> (host_wr && host_idx == 3'd7));
endmodule

// File: rtl/emi_window.sv
module emi_window
    import emi_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         host_sel,
    input  logic         host_wr,
    input  logic [2:0]   host_idx,
    input  logic [7:0]   host_wdata,
    output logic [7:0]   host_rdata,
    output logic         host_ready,
    output logic         mem_en,
    output logic         mem_we,
    output logic [3:0]   mem_be,
    output logic [12:0]  mem_addr,
    output logic [31:0]  mem_wdata,
    input  logic [31:0]  mem_rdata
);
    ctl_t               ctl;
    mode_e              mode;
    logic [WADDR_W-1:0] waddr;
    logic [WORD_W-1:0]  hold;

    emi_addr_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .ld_lo  (ctl.ld_lo),
        .ld_hi  (ctl.ld_hi),
        .inc    (ctl.inc),
        .lo_val (host_wdata),
        .hi_val (host_wdata[HI_W-1:0]),
        .waddr  (waddr),
        .mode   (mode)
    );

    emi_hold u_hold (
        .clk     (clk),
        .rst     (rst),
        .clr     (ctl.clr),
        .ld_word (ctl.ld_word),
        .word_in (mem_rdata),
        .ld_lane (ctl.ld_lane),
        .lane    (ctl.lane),
        .bval    (ctl.bval),
        .hold    (hold)
    );

    emi_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .host_sel   (host_sel),
        .host_wr    (host_wr),
        .host_idx   (host_idx),
        .host_wdata (host_wdata),
        .mode       (mode),
        .waddr      (waddr),
        .hold       (hold),
        .mem_rdata  (mem_rdata),
        .ctl        (ctl),
        .host_ready (host_ready),
        .host_rdata (host_rdata),
        .mem_en     (mem_en),
        .mem_we     (mem_we),
        .mem_be     (mem_be),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata)
    );

    // R6 R7
    step_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.inc |=> waddr == $past(waddr) + 1'b1);
    // R9
    cancel_chk: assert property (@(posedge clk) disable iff (rst)
        (host_sel && host_wr && host_ready && host_idx[2:1] == 2'b00) |-> !mem_en);
    // R11
    unused_chk: assert property (@(posedge clk) disable iff (rst)
        (host_sel && host_ready && host_idx[2:1] == 2'b01) |-> (host_rdata == 8'h00 && !mem_en));
endmodule

// File: tb/sim_emi_window.sv
`timescale 1ns/1ps
module sim_emi_window;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_sel = 1'b0;
    logic        host_wr = 1'b0;
    logic [2:0]  host_idx = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        host_ready;
    logic        mem_en, mem_we;
    logic [3:0]  mem_be;
    logic [12:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;

    int total = 0;
    int bad = 0;

    logic [31:0] mem [64];
    int          wr_cnt = 0;
    int          rd_cnt = 0;
    logic [12:0] last_wa = '0;
    logic [12:0] last_ra = '0;
    logic [31:0] last_wd = '0;
    logic [3:0]  last_be = '0;

    always #2 clk = ~clk;

    emi_window u0 (
        .clk(clk), .rst(rst), .host_sel(host_sel), .host_wr(host_wr),
        .host_idx(host_idx), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_ready(host_ready), .mem_en(mem_en), .mem_we(mem_we),
        .mem_be(mem_be), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] init_word(int i);
        return {8'(i + 8'h40), 8'(i + 8'h30), 8'(i + 8'h20), 8'(i + 8'h10)};
    endfunction

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) begin
                for (int l = 0; l < 4; l++)
                    if (mem_be[l]) mem[mem_addr[5:0]][l*8 +: 8] <= mem_wdata[l*8 +: 8];
                wr_cnt  <= wr_cnt + 1;
                last_wa <= mem_addr;
                last_wd <= mem_wdata;
                last_be <= mem_be;
            end else begin
                mem_rdata <= mem[mem_addr[5:0]];
                rd_cnt    <= rd_cnt + 1;
                last_ra   <= mem_addr;
            end
        end
    end

    task automatic report();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic wr, input logic [2:0] idx, input logic [7:0] wd,
                       output logic [7:0] rd, output int waits);
        @(negedge clk);
        host_sel = 1'b1; host_wr = wr; host_idx = idx; host_wdata = wd;
        waits = 0;
        #0.5;
        while (!host_ready && waits < 20) begin
            @(negedge clk); #0.5;
            waits++;
        end
        rd = host_rdata;
        @(posedge clk);
        @(negedge clk);
        host_sel = 1'b0; host_wr = 1'b0;
    endtask

    task automatic wr(input logic [2:0] idx, input logic [7:0] d);
        logic [7:0] r; int w;
        acc(1'b1, idx, d, r, w);
    endtask

    task automatic rdb(input logic [2:0] idx, output logic [7:0] d);
        int w;
        acc(1'b0, idx, 8'h00, d, w);
    endtask

    task automatic setaddr(input logic [12:0] wa, input logic [1:0] m);
        wr(3'd1, {1'b0, wa[12:6]});
        wr(3'd0, {wa[5:0], m});
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rdb(3'd0, d); chk("R1 addr lo after reset", d, 8'h00);
        rdb(3'd1, d); chk("R1 addr hi after reset", d, 8'h00);
    endtask

    task automatic t_addr();
        logic [7:0] d;
        wr(3'd0, 8'hB6); rdb(3'd0, d); chk("R2 addr lo readback", d, 8'hB6);
        wr(3'd1, 8'hD5); rdb(3'd1, d); chk("R3 addr hi bit7 ignored", d, 8'h55);
        rdb(3'd0, d); chk("R2 addr lo kept", d, 8'hB6);
    endtask

    task automatic t_word_read();
        logic [7:0] d; int w; int r0;
        setaddr(13'd3, 2'b10);
        r0 = rd_cnt;
        acc(1'b0, 3'd4, 8'h00, d, w);
        chk("R10 fetch wait cycles", w, 1);
        chk("R4 lane0 data", d, 8'h13);
        chk("R4 fetch address", last_ra, 13'd3);
        chk("R4 one read", rd_cnt, r0 + 1);
        for (int l = 1; l < 4; l++) begin
            acc(1'b0, 3'(4 + l), 8'h00, d, w);
            chk("R10 staged lane no wait", w, 0);
            chk("R4 staged lane data", d, 32'(8'h13 + 8'(l * 16)));
        end
        chk("R4 no extra reads", rd_cnt, r0 + 1);
        rdb(3'd0, d); chk("R6 mode 10 holds address", d, 8'h0E);
    endtask

    task automatic t_word_write();
        logic [7:0] d; int w0; int w;
        setaddr(13'd5, 2'b11);
        w0 = wr_cnt;
        wr(3'd4, 8'h11); wr(3'd5, 8'h22); wr(3'd6, 8'h33);
        chk("R5 staging only", wr_cnt, w0);
        wr(3'd7, 8'h44);
        chk("R5 one write", wr_cnt, w0 + 1);
        chk("R5 write address", last_wa, 13'd5);
        chk("R5 write word", last_wd, 32'h44332211);
        chk("R5 all enables", last_be, 4'hF);
        rdb(3'd0, d); chk("R6 advance after write", d, 8'h1B);
        wr(3'd4, 8'hA1); wr(3'd5, 8'hA2); wr(3'd6, 8'hA3); wr(3'd7, 8'hA4);
        chk("R6 streamed address", last_wa, 13'd6);
        chk("R6 streamed word", mem[6], 32'hA4A3A2A1);
        setaddr(13'd5, 2'b11);
        for (int i = 0; i < 8; i++) begin
            logic [7:0] exp;
            exp = (i < 4) ? 8'(8'h11 * (i + 1)) : 8'(8'hA1 + (i - 4));
            acc(1'b0, 3'(4 + (i % 4)), 8'h00, d, w);
            chk("R6 read stream", d, exp);
        end
        rdb(3'd0, d); chk("R6 advance after reads", d, 8'h1F);
    endtask

    task automatic t_wrap();
        logic [7:0] d;
        wr(3'd1, 8'h7F); wr(3'd0, 8'hFF);
        rdb(3'd1, d); chk("R3 hi field top", d, 8'h7F);
        wr(3'd4, 8'h01); wr(3'd5, 8'h02); wr(3'd6, 8'h03); wr(3'd7, 8'h04);
        chk("R7 write at top", last_wa, 13'h1FFF);
        rdb(3'd0, d); chk("R7 wrap lo", d, 8'h03);
        rdb(3'd1, d); chk("R7 wrap hi", d, 8'h00);
    endtask

    task automatic t_byte();
        logic [7:0] d; int w; int w0;
        setaddr(13'd10, 2'b00);
        acc(1'b0, 3'd6, 8'h00, d, w);
        chk("R8 byte read wait", w, 1);
        chk("R8 byte read lane2", d, 8'h3A);
        w0 = wr_cnt;
        wr(3'd5, 8'hEE);
        chk("R8 byte write count", wr_cnt, w0 + 1);
        chk("R8 byte write enable", last_be, 4'b0010);
        chk("R8 other lanes intact", mem[10], 32'h4A3AEE1A);
        wr(3'd7, 8'h99);
        chk("R8 lane3 single enable", last_be, 4'b1000);
        rdb(3'd0, d); chk("R8 no advance", d, 8'h28);
        setaddr(13'd10, 2'b01);
        acc(1'b0, 3'd7, 8'h00, d, w);
        chk("R8 mode 01 read lane3", d, 8'h99);
        chk("R8 mode 01 fetch wait", w, 1);
        rdb(3'd0, d); chk("R8 mode 01 no advance", d, 8'h29);
    endtask

    task automatic t_cancel();
        int w0;
        setaddr(13'd12, 2'b10);
        wr(3'd4, 8'h5A); wr(3'd5, 8'h6B);
        w0 = wr_cnt;
        wr(3'd0, 8'h32);
        chk("R9 no write on address write", wr_cnt, w0);
        wr(3'd7, 8'h7C);
        chk("R9 staged bytes dropped", last_wd, 32'h7C000000);
        chk("R9 write address", last_wa, 13'd12);
    endtask

    task automatic t_unused();
        logic [7:0] d0, d; int w0, r0;
        rdb(3'd0, d0);
        w0 = wr_cnt; r0 = rd_cnt;
        wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
        rdb(3'd2, d); chk("R11 index 2 reads zero", d, 8'h00);
        rdb(3'd3, d); chk("R11 index 3 reads zero", d, 8'h00);
        rdb(3'd0, d); chk("R11 address unchanged", d, d0);
        chk("R11 no memory write", wr_cnt, w0);
        chk("R11 no memory read", rd_cnt, r0);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = init_word(i);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_addr();
        t_word_read();
        t_word_write();
        t_wrap();
        t_byte();
        t_cancel();
        t_unused();
        report();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        report();
        $finish;
    end
endmodule